// File: doc/BRIEF.md
# Two-Channel Event Interrupt Status Block

This block gathers transfer events reported by two command channels and folds them into a single interrupt request. Each channel owns an 8-bit slice of a 32-bit raw status word. Five of the bits in each slice hold an event kind: command done, receive overrun, transmit underrun, poll timeout and invalid control. An event pulse from a channel latches its bit. The bit then stays set until software writes a one to it.

A mask word sits beside the raw status. A read-only view presents the raw status ANDed with the mask. The interrupt output is high whenever that masked view is non-zero. Software reaches the three words through a plain register port. Writes take effect on the clock edge. Reads are combinational on the address.

Top module: `chan_irq_status`

## Requirements
- R1: After reset the raw status, the mask and the masked view all read zero, and `irq` is low.
- R2: A pulse on `evt_pulse[c*5+k]` sets raw status bit `c*8+k` at the next clock edge. Within each channel, k=0 is command done, k=1 is receive overrun, k=2 is transmit underrun, k=3 is poll timeout and k=4 is invalid control.
- R3: A latched raw bit stays set until a write to offset 0x08 carries a one in that bit position. Bits written as zero are left unchanged.
- R4: When an event pulse and a write-one-to-clear hit the same bit in the same cycle, the bit ends up set.
- R5: Offset 0x0C reads the raw status ANDed with the mask. Writes to 0x0C change neither the raw status nor the mask.
- R6: The mask at offset 0x10 is read/write. Writing zero to it drops `irq` without clearing any latched raw bit.
- R7: `irq` is high exactly when the masked view is non-zero.
- R8: Bits outside the implemented event positions (0x00001F1F) read as zero in every word and ignore writes.
- R9: Writing 0xFF001F1F to offset 0x08 clears every latched event.
- R10: Reads from any other offset return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_pulse | input | 10 | One-cycle event pulses, channel c kind k on bit c*5+k |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Byte offset of the register access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for `reg_addr` |
| irq | output | 1 | Interrupt request, high while any unmasked event is latched |

## Verification
On every cycle, the in-RTL assertions check three things. An event sets its bit. A bit holds unless cleared. A clear without a coincident event empties the bit. They also check that the mask moves only on a write to its own offset, that `irq` never rises without a latched raw bit, and that unimplemented read bits stay zero. Some behaviours need the bench's scenarios, because each depends on the exact bit mapping at the ports:
- the event-to-bit placement for each channel
- the read-only nature of the masked view
- the mask-to-zero case that keeps the latched status
- the clear-all pattern
- decoding of unused offsets

// File: rtl/chirq_pkg.sv
package chirq_pkg;
  localparam int SLICE_W = 8;
  localparam int KINDS   = 5;
  localparam int REG_W   = 32;
  localparam int ADDR_W  = 8;

  localparam logic [ADDR_W-1:0] OFS_RAW    = 8'h08;
  localparam logic [ADDR_W-1:0] OFS_MASKED = 8'h0C;
  localparam logic [ADDR_W-1:0] OFS_MASK   = 8'h10;

  // Bits that hold an event for a given channel count.
  function automatic logic [REG_W-1:0] impl_bits(input int nch);
    logic [REG_W-1:0] m;
    m = '0;
    for (int c = 0; c < nch; c++)
      for (int k = 0; k < KINDS; k++)
        m[c*SLICE_W+k] = 1'b1;
    return m;
  endfunction

  // Masked view of the status word.
  function automatic logic [REG_W-1:0] apply_mask(input logic [REG_W-1:0] raw,
                                                  input logic [REG_W-1:0] msk);
    return raw & msk;
  endfunction
endpackage

// File: rtl/chirq_evt_latch.sv
module chirq_evt_latch #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] evt,
  input  logic [W-1:0] clr,
  output logic [W-1:0] stat
);
  logic [W-1:0] stat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= (stat_q & ~clr) | evt;
  end

  assign stat = stat_q;

  for (genvar k = 0; k < W; k++) begin : g_chk
    assert_evt_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
      evt[k] |=> stat[k]);
    assert_evt_beats_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (evt[k] && clr[k]) |=> stat[k]);
    assert_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (stat[k] && !clr[k]) |=> stat[k]);
    assert_w1c_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (clr[k] && !evt[k]) |=> !stat[k]);
  end
endmodule

// File: rtl/chirq_mask_reg.sv
module chirq_mask_reg #(
  parameter int          W    = 32,
  parameter logic [W-1:0] IMPL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] mask
);
  logic [W-1:0] mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  mask_q <= '0;
    else if (we) mask_q <= wdata & IMPL;
  end

  assign mask = mask_q;

  assert_mask_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(mask));
  assert_mask_unimpl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mask & ~IMPL) == '0);
endmodule

// File: rtl/chan_irq_status.sv
module chan_irq_status
  import chirq_pkg::*;
#(
  parameter int NUM_CHAN = 2,
  localparam int EVT_W   = NUM_CHAN * KINDS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [EVT_W-1:0]  evt_pulse,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  output logic              irq
);
  localparam logic [REG_W-1:0] IMPL = impl_bits(NUM_CHAN);

  logic              raw_clr_wr;
  logic              mask_wr;
  logic [REG_W-1:0]  raw_w;
  logic [REG_W-1:0]  mask_w;
  logic [REG_W-1:0]  masked_w;

  assign raw_clr_wr = reg_wr && (reg_addr == OFS_RAW);
  assign mask_wr    = reg_wr && (reg_addr == OFS_MASK);

  for (genvar c = 0; c < NUM_CHAN; c++) begin : g_chan
    logic [KINDS-1:0] clr_c;
    logic [KINDS-1:0] stat_c;
    assign clr_c = raw_clr_wr ? reg_wdata[c*SLICE_W +: KINDS] : '0;
    chirq_evt_latch #(.W(KINDS)) u_latch (
      .clk  (clk),
      .rst_n(rst_n),
      .evt  (evt_pulse[c*KINDS +: KINDS]),
      .clr  (clr_c),
      .stat (stat_c)
    );
    assign raw_w[c*SLICE_W +: SLICE_W] = {{(SLICE_W-KINDS){1'b0}}, stat_c};
  end
  if (NUM_CHAN*SLICE_W < REG_W) begin : g_pad
    assign raw_w[REG_W-1:NUM_CHAN*SLICE_W] = '0;
  end

  chirq_mask_reg #(.W(REG_W), .IMPL(IMPL)) u_mask (
    .clk  (clk),
    .rst_n(rst_n),
    .we   (mask_wr),
    .wdata(reg_wdata),
    .mask (mask_w)
  );

  assign masked_w = apply_mask(raw_w, mask_w);
  assign irq      = |masked_w;

  always_comb begin
    unique case (reg_addr)
      OFS_RAW:    reg_rdata = raw_w;
      OFS_MASKED: reg_rdata = masked_w;
      OFS_MASK:   reg_rdata = mask_w;
      default:    reg_rdata = '0;
    endcase
  end

  assert_irq_needs_raw_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (raw_w != '0));
  assert_rd_unimpl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata & ~IMPL) == '0);
endmodule

// File: tb/sim_chan_irq_status.sv
module sim_chan_irq_status;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [9:0]  evt_pulse = '0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  chan_irq_status u0 (
    .clk(clk), .rst_n(rst_n), .evt_pulse(evt_pulse), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  // {evt, wr, addr, wdata, exp_raw, exp_masked, exp_irq}
  localparam int NV = 13;
  localparam logic [115:0] TBL [NV] = '{
    {10'h001, 1'b0, 8'h00, 32'h0000_0000, 32'h0000_0001, 32'h0000_0000, 1'b0}, // R2 ch0 done
    {10'h000, 1'b1, 8'h10, 32'h0000_0001, 32'h0000_0001, 32'h0000_0001, 1'b1}, // R6 R7 unmask
    {10'h200, 1'b0, 8'h00, 32'h0000_0000, 32'h0000_1001, 32'h0000_0001, 1'b1}, // R2 ch1 invalid ctrl
    {10'h000, 1'b1, 8'h08, 32'h0000_0001, 32'h0000_1000, 32'h0000_0000, 1'b0}, // R3 w1c
    {10'h000, 1'b1, 8'h10, 32'hFFFF_FFFF, 32'h0000_1000, 32'h0000_1000, 1'b1}, // R8 mask all
    {10'h082, 1'b0, 8'h00, 32'h0000_0000, 32'h0000_1402, 32'h0000_1402, 1'b1}, // R2 rx ovr, ch1 tx under
    {10'h000, 1'b1, 8'h08, 32'h0000_0000, 32'h0000_1402, 32'h0000_1402, 1'b1}, // R3 zero write
    {10'h000, 1'b1, 8'h0C, 32'hFFFF_FFFF, 32'h0000_1402, 32'h0000_1402, 1'b1}, // R5 ro view
    {10'h000, 1'b1, 8'h10, 32'h0000_0000, 32'h0000_1402, 32'h0000_0000, 1'b0}, // R6 mask zero
    {10'h000, 1'b1, 8'h10, 32'h0000_0400, 32'h0000_1402, 32'h0000_0400, 1'b1}, // R5 partial mask
    {10'h002, 1'b1, 8'h08, 32'h0000_1402, 32'h0000_0002, 32'h0000_0000, 1'b0}, // R4 event wins
    {10'h3FF, 1'b0, 8'h00, 32'h0000_0000, 32'h0000_1F1F, 32'h0000_0400, 1'b1}, // R2 all kinds
    {10'h000, 1'b1, 8'h08, 32'hFF00_1F1F, 32'h0000_0000, 32'h0000_0000, 1'b0}  // R9 clear all
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic step(input logic [9:0] e, input logic w, input logic [7:0] a,
                      input logic [31:0] wd);
    @(negedge clk);
    evt_pulse = e; reg_wr = w; reg_addr = a; reg_wdata = wd;
    @(posedge clk);
    #1;
    evt_pulse = '0; reg_wr = 1'b0; reg_wdata = '0;
  endtask

  initial begin
    logic [31:0] d;
    #3;
    rd(8'h08, d); check("R1 raw", d, 32'h0);
    rd(8'h10, d); check("R1 mask", d, 32'h0);
    check("R1 irq", {31'b0, irq}, 32'h0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      step(TBL[i][115:106], TBL[i][105], TBL[i][104:97], TBL[i][96:65]);
      rd(8'h08, d); check($sformatf("R2/R3 raw vec%0d", i), d, TBL[i][64:33]);
      rd(8'h0C, d); check($sformatf("R5 masked vec%0d", i), d, TBL[i][32:1]);
      check($sformatf("R7 irq vec%0d", i), {31'b0, irq}, {31'b0, TBL[i][0]});
    end

    // R8: mask readback keeps only implemented bits
    step(10'h000, 1'b1, 8'h10, 32'hFFFF_FFFF);
    rd(8'h10, d); check("R8 mask readback", d, 32'h0000_1F1F);
    // R10: other offsets read zero even with events latched
    step(10'h3FF, 1'b0, 8'h00, 32'h0);
    rd(8'h04, d); check("R10 unused offset", d, 32'h0);
    rd(8'h00, d); check("R10 offset zero", d, 32'h0);
    // R6: mask to zero leaves status latched
    step(10'h000, 1'b1, 8'h10, 32'h0);
    rd(8'h08, d); check("R6 raw kept", d, 32'h0000_1F1F);
    check("R6 irq low", {31'b0, irq}, 32'h0);
    // R1: reset in mid-run clears everything
    rst_n = 1'b0;
    #1;
    rd(8'h08, d); check("R1 raw after reset", d, 32'h0);
    @(negedge clk); rst_n = 1'b1;

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #100000;
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule